// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Controller

This block is a memory-mapped controller for a single bank of 32 general-purpose pins, split into four 8-bit ports. Each port owns one byte lane of every one-bit-per-pin register. Software reaches the registers over a simple bus that has a byte address, a write enable, per-lane write strobes, write data and combinational read data. Through that bus it sets pin direction, drives output values, samples inputs, keeps a pin-select word, programs a two-bit interrupt mode for each pin, and reads and clears pending interrupt events.

Inputs pass through a multi-stage synchroniser. The synchronised value is compared with its value one clock earlier to find rising and falling edges. An edge whose polarity the pin's mode accepts latches a pending bit. The OR of all pending bits forms one interrupt line to a parent controller. Software services the line by reading the status word and writing ones back to the bits it has handled.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, pin_oe and irq_out are 0, and the direction (0x08), output latch, mode (0x14, 0x18) and status (0x10) words all read 0.
- R2: The word at byte address 0x08 holds direction, with bit n for pin n. A 1 drives pin_oe[n] high (output) and a 0 makes the pin an input. The register reads back.
- R3: A write to 0x0C loads the output latch, which appears on pin_out the cycle after the write. A read of 0x0C returns the latch bit for output pins and, for input pins, the pin value after SYNC_STAGES (2) clock edges of synchronisation.
- R4: Write strobe bit k enables byte lane k (bits 8k+7..8k, port k). Lanes whose strobe is 0 keep their old contents.
- R5: The mode of pin n sits at bits 2n+1..2n of the 64-bit mode space. Port p's 16-bit field is at byte address 0x14+2p, so 0x14 holds pins 0-15 and 0x18 holds pins 16-31. Mode encodings: 00 disabled (edges never set status), 01 falling edge, 10 rising edge, 11 both edges.
- R6: A pin change that the pin's mode accepts sets status bit n on the third rising clock edge after the change. irq_out is high whenever any status bit is set.
- R7: Writing 1 to a status bit at 0x10 clears it, and writing 0 leaves it unchanged. Each port's status byte is cleared only through its own strobe lane.
- R8: If a qualifying edge and a write-1 clear of the same status bit fall in the same cycle, the bit stays set.
- R9: The pin-select word at 0x00 is stored and read back. It has no effect on pin_out or pin_oe.
- R10: Word 0x04, words at or above 0x1C, and any address with bits 1..0 not zero read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register access |
| bus_wr | input | 1 | Write enable for the current cycle |
| bus_wstrb | input | 4 | Per-byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 32 | Asynchronous pin input levels |
| pin_out | output | 32 | Output latch value |
| pin_oe | output | 32 | Output enable per pin (direction) |
| irq_out | output | 1 | Combined pending-interrupt line |

## Verification
The assertions assume that pin_in is low while reset is active. If it is not, the first synchronised sample after reset can look like a rising edge. They also assume the bus write enable is low during reset, so that no write is seen in the first cycle after release. The stimulus keeps both inputs low until reset is released. After that it changes pins and bus signals only on falling clock edges, so every pin change reaches the synchroniser as a clean level. Full-strobe write checks rely on the bench driving complete words to the direction, data and status registers, and the partial-strobe and misaligned cases are exercised on top of that.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int PORT_W    = 8;
    localparam int NUM_PORTS = 4;
    localparam int PIN_CNT   = PORT_W * NUM_PORTS;
    localparam int MODE_BITS = 2;
    localparam int MODE_W    = PIN_CNT * MODE_BITS;
    localparam int ADDR_W    = 5;

    typedef enum logic [2:0] {
        W_SEL     = 3'd0,
        W_RSVD    = 3'd1,
        W_DIR     = 3'd2,
        W_DATA    = 3'd3,
        W_STAT    = 3'd4,
        W_MODE_LO = 3'd5,
        W_MODE_HI = 3'd6,
        W_SPARE   = 3'd7
    } word_e;

    typedef struct packed {
        logic [PIN_CNT-1:0] sel;
        logic [PIN_CNT-1:0] dir;
        logic [PIN_CNT-1:0] dout;
        logic [PIN_CNT-1:0] stat;
        logic [MODE_W-1:0]  mode;
    } bank_regs_t;

    function automatic logic [PIN_CNT-1:0] lane_mask(input logic [NUM_PORTS-1:0] strb);
        logic [PIN_CNT-1:0] m;
        for (int b = 0; b < NUM_PORTS; b++) begin
            m[b*PORT_W +: PORT_W] = {PORT_W{strb[b]}};
        end
        return m;
    endfunction

    function automatic logic [PIN_CNT-1:0] merge_lanes(
        input logic [PIN_CNT-1:0]   old_v,
        input logic [PIN_CNT-1:0]   new_v,
        input logic [NUM_PORTS-1:0] strb
    );
        logic [PIN_CNT-1:0] m;
        m = lane_mask(strb);
        return (old_v & ~m) | (new_v & m);
    endfunction
endpackage

// File: rtl/gpio_input_sync.sv
module gpio_input_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   level,
    input  logic [2*PINS-1:0] mode,
    output logic [PINS-1:0]   evt
);
    logic [PINS-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic rise, fall;
        assign rise   = level[i] & ~prev_q[i];
        assign fall   = ~level[i] & prev_q[i];
        // mode[2i+1] accepts rising edges, mode[2i] accepts falling edges
        assign evt[i] = (mode[2*i+1] & rise) | (mode[2*i] & fall);
    end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_bank_pkg::*;
(
    input  word_e              widx,
    input  logic               aligned,
    input  bank_regs_t         regs,
    input  logic [PIN_CNT-1:0] pin_sync,
    output logic [PIN_CNT-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (widx)
                W_SEL:     rdata = regs.sel;
                W_DIR:     rdata = regs.dir;
                W_DATA:    rdata = (regs.dout & regs.dir) | (pin_sync & ~regs.dir);
                W_STAT:    rdata = regs.stat;
                W_MODE_LO: rdata = regs.mode[PIN_CNT-1:0];
                W_MODE_HI: rdata = regs.mode[MODE_W-1:PIN_CNT];
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [NUM_PORTS-1:0] bus_wstrb,
    input  logic [PIN_CNT-1:0]   bus_wdata,
    output logic [PIN_CNT-1:0]   bus_rdata,
    input  logic [PIN_CNT-1:0]   pin_in,
    output logic [PIN_CNT-1:0]   pin_out,
    output logic [PIN_CNT-1:0]   pin_oe,
    output logic                 irq_out
);
    bank_regs_t         regs_d, regs_q;
    word_e              widx;
    logic               aligned;
    logic [PIN_CNT-1:0] pin_sync;
    logic [PIN_CNT-1:0] evt_vec;
    logic [PIN_CNT-1:0] stat_vec;
    logic [PIN_CNT-1:0] stat_clr;

    assign widx    = word_e'(bus_addr[ADDR_W-1:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);

    gpio_input_sync #(.WIDTH(PIN_CNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_sync)
    );

    gpio_edge_detect #(.PINS(PIN_CNT)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .level(pin_sync),
        .mode (regs_q.mode),
        .evt  (evt_vec)
    );

    gpio_read_mux u_rmux (
        .widx    (widx),
        .aligned (aligned),
        .regs    (regs_q),
        .pin_sync(pin_sync),
        .rdata   (bus_rdata)
    );

    always_comb begin
        regs_d   = regs_q;
        stat_clr = '0;
        if (bus_wr && aligned) begin
            case (widx)
                W_SEL:     regs_d.sel  = merge_lanes(regs_q.sel,  bus_wdata, bus_wstrb);
                W_DIR:     regs_d.dir  = merge_lanes(regs_q.dir,  bus_wdata, bus_wstrb);
                W_DATA:    regs_d.dout = merge_lanes(regs_q.dout, bus_wdata, bus_wstrb);
                W_STAT:    stat_clr    = bus_wdata & lane_mask(bus_wstrb);
                W_MODE_LO: regs_d.mode[PIN_CNT-1:0] =
                               merge_lanes(regs_q.mode[PIN_CNT-1:0], bus_wdata, bus_wstrb);
                W_MODE_HI: regs_d.mode[MODE_W-1:PIN_CNT] =
                               merge_lanes(regs_q.mode[MODE_W-1:PIN_CNT], bus_wdata, bus_wstrb);
                default:   ;
            endcase
        end
        // a new event takes priority over a clear in the same cycle
        regs_d.stat = (regs_q.stat & ~stat_clr) | evt_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign stat_vec = regs_q.stat;
    assign pin_out  = regs_q.dout;
    assign pin_oe   = regs_q.dir;
    assign irq_out  = |regs_q.stat;
endmodule

// File: rtl/gpio_edge_bank_checker.sv
module gpio_edge_bank_checker
    import gpio_bank_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic [NUM_PORTS-1:0] bus_wstrb,
    input logic [PIN_CNT-1:0]   bus_wdata,
    input logic [PIN_CNT-1:0]   pin_out,
    input logic [PIN_CNT-1:0]   pin_oe,
    input logic [PIN_CNT-1:0]   stat_vec,
    input logic [PIN_CNT-1:0]   evt_vec
);
    logic full_dir_wr, full_data_wr, full_stat_wr, any_dir_wr;

    assign any_dir_wr   = bus_wr && (bus_addr == 5'h08);
    assign full_dir_wr  = any_dir_wr && (bus_wstrb == 4'hF);
    assign full_data_wr = bus_wr && (bus_addr == 5'h0C) && (bus_wstrb == 4'hF);
    assign full_stat_wr = bus_wr && (bus_addr == 5'h10) && (bus_wstrb == 4'hF);

    a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (!rst_n)
        full_dir_wr |=> (pin_oe == $past(bus_wdata)));

    a_r2_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !any_dir_wr |=> $stable(pin_oe));

    a_r3_out_follows_data: assert property (@(posedge clk) disable iff (!rst_n)
        full_data_wr |=> (pin_out == $past(bus_wdata)));

    a_r6_set_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_vec & ~$past(stat_vec) & ~$past(evt_vec)) == '0));

    a_r7_write_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        full_stat_wr |=> ((stat_vec & $past(bus_wdata) & ~$past(evt_vec)) == '0));

    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (($past(evt_vec) & ~stat_vec) == '0));
endmodule

bind gpio_edge_bank gpio_edge_bank_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wstrb(bus_wstrb),
    .bus_wdata(bus_wdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .stat_vec (stat_vec),
    .evt_vec  (evt_vec)
);

// File: tb/gpio_edge_bank_test.sv
module gpio_edge_bank_test;
    localparam int CLK_PERIOD = 10;

    localparam logic [1:0] K_REG = 2'd0;
    localparam logic [1:0] K_OE  = 2'd1;
    localparam logic [1:0] K_OUT = 2'd2;
    localparam logic [1:0] K_IRQ = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic [4:0]  addr;
        logic [31:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    item_t item_q[$];
    string tag_q[$];
    event  mon_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_bank uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wstrb(bus_wstrb),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .irq_out  (irq_out)
    );

    // monitor: pops expected items and compares with what the design shows
    initial begin
        forever begin
            item_t it;
            string tg;
            logic [31:0] act;
            @(mon_ev);
            #1;
            it = item_q.pop_front();
            tg = tag_q.pop_front();
            case (it.kind)
                K_REG:   act = bus_rdata;
                K_OE:    act = pin_oe;
                K_OUT:   act = pin_out;
                default: act = {31'b0, irq_out};
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s kind=%0d addr=0x%02h actual=0x%08h expected=0x%08h",
                         tg, it.kind, it.addr, act, it.exp);
            end
        end
    end

    // driver side: push an expected item and trigger the monitor
    task automatic expect_item(input logic [1:0] kind, input logic [4:0] addr,
                               input logic [31:0] exp, input string tg);
        item_t it;
        @(negedge clk);
        bus_addr = addr;
        it.kind = kind;
        it.addr = addr;
        it.exp  = exp;
        item_q.push_back(it);
        tag_q.push_back(tg);
        ->mon_ev;
        #2;
    endtask

    task automatic bus_write(input logic [4:0] addr, input logic [31:0] data,
                             input logic [3:0] strb);
        @(negedge clk);
        bus_addr  = addr;
        bus_wdata = data;
        bus_wstrb = strb;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wstrb = '0;
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_item(K_OE,  5'h00, 32'h0, "R1 pin_oe");
        expect_item(K_IRQ, 5'h00, 32'h0, "R1 irq_out");
        expect_item(K_REG, 5'h08, 32'h0, "R1 dir");
        expect_item(K_REG, 5'h0C, 32'h0, "R1 data");
        expect_item(K_REG, 5'h10, 32'h0, "R1 status");
        expect_item(K_REG, 5'h14, 32'h0, "R1 mode lo");
        expect_item(K_REG, 5'h18, 32'h0, "R1 mode hi");

        // R2: direction
        bus_write(5'h08, 32'hFF00_00F0, 4'hF);
        expect_item(K_OE,  5'h00, 32'hFF00_00F0, "R2 pin_oe");
        expect_item(K_REG, 5'h08, 32'hFF00_00F0, "R2 dir readback");

        // R3: output latch and mixed read
        bus_write(5'h0C, 32'hA5A5_A5A5, 4'hF);
        expect_item(K_OUT, 5'h00, 32'hA5A5_A5A5, "R3 pin_out");
        set_pins(32'h0F0F_0F0F);
        repeat (2) @(posedge clk);
        expect_item(K_REG, 5'h0C, 32'hA50F_0FAF, "R3 data read mix");

        // R4: only the strobed lane changes
        bus_write(5'h08, 32'hFFFF_FFFF, 4'b0100);
        expect_item(K_OE,  5'h00, 32'hFFFF_00F0, "R4 dir lane2");
        bus_write(5'h0C, 32'h0000_0000, 4'b0001);
        expect_item(K_OUT, 5'h00, 32'hA5A5_A500, "R4 data lane0");

        // R9: pin-select stored, no effect on pins
        bus_write(5'h00, 32'h1234_5678, 4'hF);
        expect_item(K_REG, 5'h00, 32'h1234_5678, "R9 select readback");
        expect_item(K_OE,  5'h00, 32'hFFFF_00F0, "R9 pin_oe untouched");
        expect_item(K_OUT, 5'h00, 32'hA5A5_A500, "R9 pin_out untouched");

        // R10: unmapped and misaligned
        bus_write(5'h04, 32'hFFFF_FFFF, 4'hF);
        expect_item(K_REG, 5'h04, 32'h0, "R10 reserved word");
        bus_write(5'h09, 32'h0000_0000, 4'hF);
        expect_item(K_OE,  5'h00, 32'hFFFF_00F0, "R10 misaligned write ignored");
        expect_item(K_REG, 5'h1C, 32'h0, "R10 word above map");

        // back to all inputs, pins low; mode 00 so no events (R5)
        bus_write(5'h08, 32'h0, 4'hF);
        set_pins(32'h0);
        repeat (4) @(posedge clk);
        expect_item(K_REG, 5'h10, 32'h0, "R5 disabled mode ignores edges");

        // R5: pin0 rising(10), pin1 falling(01), pin2 both(11), pin3 off; pin16 rising
        bus_write(5'h14, 32'h0000_0036, 4'hF);
        bus_write(5'h18, 32'h0000_0002, 4'b0011);
        expect_item(K_REG, 5'h14, 32'h0000_0036, "R5 mode lo readback");
        expect_item(K_REG, 5'h18, 32'h0000_0002, "R5 mode hi readback");

        // R6: rising on pins 0..3
        set_pins(32'h0000_000F);
        repeat (2) @(posedge clk);
        expect_item(K_REG, 5'h10, 32'h0, "R6 not yet set after two edges");
        @(posedge clk);
        expect_item(K_REG, 5'h10, 32'h0000_0005, "R6 rising sets pins 0,2");
        expect_item(K_IRQ, 5'h00, 32'h1, "R6 irq high");

        // falling on pins 0..3
        set_pins(32'h0);
        repeat (3) @(posedge clk);
        expect_item(K_REG, 5'h10, 32'h0000_0007, "R5 falling adds pins 1,2, pin3 off");

        // R7: write-one-to-clear
        bus_write(5'h10, 32'h0000_0001, 4'h1);
        expect_item(K_REG, 5'h10, 32'h0000_0006, "R7 clear bit0");
        bus_write(5'h10, 32'h0000_0000, 4'hF);
        expect_item(K_REG, 5'h10, 32'h0000_0006, "R7 zeros leave bits");
        bus_write(5'h10, 32'h0000_00FF, 4'h2);
        expect_item(K_REG, 5'h10, 32'h0000_0006, "R7 wrong lane no clear");
        bus_write(5'h10, 32'h0000_00FF, 4'h1);
        expect_item(K_REG, 5'h10, 32'h0, "R7 lane0 clear");
        expect_item(K_IRQ, 5'h00, 32'h0, "R6 irq low when empty");

        // R5: port 2 field at 0x18
        set_pins(32'h0001_0000);
        repeat (3) @(posedge clk);
        expect_item(K_REG, 5'h10, 32'h0001_0000, "R5 pin16 rising");
        bus_write(5'h10, 32'h00FF_0000, 4'h4);
        expect_item(K_REG, 5'h10, 32'h0, "R7 port2 clear");

        // R8: event and clear in the same cycle
        set_pins(32'h0001_0004);
        repeat (3) @(posedge clk);
        expect_item(K_REG, 5'h10, 32'h0000_0004, "R8 setup pin2 set");
        set_pins(32'h0001_0000);
        repeat (2) @(posedge clk);
        bus_write(5'h10, 32'h0000_0004, 4'h1);
        expect_item(K_REG, 5'h10, 32'h0000_0004, "R8 event beats clear");
        bus_write(5'h10, 32'h0000_0004, 4'h1);
        expect_item(K_REG, 5'h10, 32'h0, "R8 later clear works");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule